// File: doc/BRIEF.md
# Dual-Port Tightly Coupled Memory

This block is an on-chip 32-bit RAM with two independent ports that share one storage array. The fetch port is a point-to-point, read-only slave for a single instruction-fetch master: it presents a byte address, and the addressed word appears on the next clock edge. It has no handshake and never stalls. The bus port is a general read/write slave for a data master. Through it, code is loaded and the contents are inspected, and writes can be narrowed to single bytes with byte enables.

Neither port waits for the other. A write through the bus port lands on the clock edge at which it is presented. A read on either port returns the registered word one cycle later. When the two ports meet on the same word in the same cycle, the reader sees the word as it was before the write. Both ports take byte addresses and ignore the two lowest bits. The memory size in bytes is a parameter, with a default of 4096.

Top module: `tcm_dual_port`

## Requirements
- R1: While reset is high, and on the first edge after it, both read-valid outputs are 0 and both read-data outputs are 0.
- R2: A fetch read (fa_rd high at an edge) drives fa_rdata with the addressed word and raises fa_rvalid for exactly the following cycle.
- R3: A bus read (bs_read high at an edge) drives bs_rdata with the addressed word and raises bs_rvalid for exactly the following cycle.
- R4: A bus write (bs_write high) takes effect at the edge where it is presented, so a read on either port issued at the next edge returns the new word.
- R5: During a bus write, bit i of bs_be enables byte lane i, which is bits 8i+7 down to 8i of bs_wdata. Lanes whose enable is 0 keep their old contents.
- R6: In some cases a read and a bus write hit the same word at the same edge: a fetch read against a bus write, or a bus read and a bus write in one cycle. In both cases the read returns the contents from before the write.
- R7: In a cycle with no read on a port, that port's read-data output holds its previous value.
- R8: Only address bits above bit 1 select the word. Addresses that differ only in bits 1:0 reach the same word on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fa_rd | input | 1 | Fetch port read request |
| fa_addr | input | ADDR_W | Fetch port byte address |
| fa_rdata | output | 32 | Fetch port read word |
| fa_rvalid | output | 1 | Fetch read data valid, one cycle after request |
| bs_read | input | 1 | Bus port read request |
| bs_write | input | 1 | Bus port write request |
| bs_addr | input | ADDR_W | Bus port byte address |
| bs_be | input | 4 | Bus write byte enables, bit i for byte lane i |
| bs_wdata | input | 32 | Bus write word |
| bs_rdata | output | 32 | Bus port read word |
| bs_rvalid | output | 1 | Bus read data valid, one cycle after request |

## Verification
The hardest case to reach is a same-word collision. It needs a fetch read and a bus write to name the same word at the same edge, with byte enables that change only some lanes, so that an old-versus-new mix-up shows in the data. The stimulus first fills every word through the bus port with a distinct pattern. It then issues fetch reads and bus writes to the same word together, and also a bus read combined with a write to that word. Some of these use partial enables. Each collision is followed by reads that show the write did land.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int WORD_BITS = 32;
  localparam int LANES     = WORD_BITS / 8;

  // Word index of a byte address: the two lowest bits never select storage.
  function automatic int unsigned word_of(input logic [31:0] byte_addr);
    return byte_addr >> 2;
  endfunction

  // True when byte lane 'lane' is enabled in a byte-enable vector.
  function automatic logic lane_on(input logic [LANES-1:0] be, input int lane);
    return be[lane];
  endfunction
endpackage

// File: rtl/tcm_lane.sv
module tcm_lane #(
  parameter int WORDS = 1024,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  output logic [7:0]       a_q,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [7:0]       b_d,
  output logic [7:0]       b_q
);
  logic [7:0] store [WORDS];

  // Storage: written on the edge the request is seen.
  always_ff @(posedge clk) begin
    if (b_we) store[b_idx] <= b_d;
  end

  // Read registers sample the array before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= store[a_idx];
      if (b_en) b_q <= store[b_idx];
    end
  end
endmodule

// File: rtl/tcm_rsp.sv
module tcm_rsp (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic vld
);
  always_ff @(posedge clk) begin
    if (rst) vld <= 1'b0;
    else     vld <= req;
  end
endmodule

// File: rtl/tcm_dual_port.sv
module tcm_dual_port #(
  parameter int MEM_BYTES = 4096,
  localparam int ADDR_W = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fa_rd,
  input  logic [ADDR_W-1:0] fa_addr,
  output logic [31:0]       fa_rdata,
  output logic              fa_rvalid,
  input  logic              bs_read,
  input  logic              bs_write,
  input  logic [ADDR_W-1:0] bs_addr,
  input  logic [3:0]        bs_be,
  input  logic [31:0]       bs_wdata,
  output logic [31:0]       bs_rdata,
  output logic              bs_rvalid
);
  import tcm_pkg::*;

  localparam int WORDS = MEM_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  logic [IDX_W-1:0] a_idx;
  logic [IDX_W-1:0] b_idx;
  logic             collide;

  assign a_idx   = IDX_W'(word_of(32'(fa_addr)));
  assign b_idx   = IDX_W'(word_of(32'(bs_addr)));
  // Named event for the checker: fetch read meets a bus write on one word.
  assign collide = fa_rd && bs_write && (a_idx == b_idx);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tcm_lane #(.WORDS(WORDS)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .a_en  (fa_rd),
      .a_idx (a_idx),
      .a_q   (fa_rdata[8*g +: 8]),
      .b_en  (bs_read),
      .b_we  (bs_write && lane_on(bs_be, g)),
      .b_idx (b_idx),
      .b_d   (bs_wdata[8*g +: 8]),
      .b_q   (bs_rdata[8*g +: 8])
    );
  end

  tcm_rsp u_fa_rsp (.clk(clk), .rst(rst), .req(fa_rd),   .vld(fa_rvalid));
  tcm_rsp u_bs_rsp (.clk(clk), .rst(rst), .req(bs_read), .vld(bs_rvalid));
endmodule

// File: rtl/tcm_dual_port_chk.sv
module tcm_dual_port_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             fa_rd,
  input logic [31:0]      fa_rdata,
  input logic             fa_rvalid,
  input logic             bs_read,
  input logic             bs_write,
  input logic [3:0]       bs_be,
  input logic [31:0]      bs_wdata,
  input logic [31:0]      bs_rdata,
  input logic             bs_rvalid,
  input logic [IDX_W-1:0] a_idx,
  input logic [IDX_W-1:0] b_idx,
  input logic             collide
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!fa_rvalid && !bs_rvalid && fa_rdata == 32'h0 && bs_rdata == 32'h0));

  p_fetch_latency_r2: assert property (@(posedge clk) disable iff (rst)
    fa_rd |=> fa_rvalid);

  p_fetch_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !fa_rd |=> !fa_rvalid);

  p_bus_latency_r3: assert property (@(posedge clk) disable iff (rst)
    bs_read |=> bs_rvalid);

  p_write_visible_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bs_write && bs_be == 4'hF) && fa_rd && !collide && a_idx == $past(b_idx))
      |=> fa_rdata == $past(bs_wdata, 2));

  p_fetch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fa_rd |=> $stable(fa_rdata));

  p_same_word_r8: assert property (@(posedge clk) disable iff (rst)
    (fa_rd && bs_read && a_idx == b_idx) |=> fa_rdata == bs_rdata);
endmodule

bind tcm_dual_port tcm_dual_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .fa_rd(fa_rd), .fa_rdata(fa_rdata), .fa_rvalid(fa_rvalid),
  .bs_read(bs_read), .bs_write(bs_write), .bs_be(bs_be), .bs_wdata(bs_wdata),
  .bs_rdata(bs_rdata), .bs_rvalid(bs_rvalid), .a_idx(a_idx), .b_idx(b_idx),
  .collide(collide)
);

// File: tb/tcm_dual_port_bench.sv
module tcm_dual_port_bench;
  localparam int MEM_BYTES = 4096;
  localparam int ADDR_W    = 12;
  localparam int NW        = MEM_BYTES / 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fa_rd = 1'b0;
  logic [ADDR_W-1:0] fa_addr = '0;
  logic [31:0]       fa_rdata;
  logic              fa_rvalid;
  logic              bs_read = 1'b0;
  logic              bs_write = 1'b0;
  logic [ADDR_W-1:0] bs_addr = '0;
  logic [3:0]        bs_be = '0;
  logic [31:0]       bs_wdata = '0;
  logic [31:0]       bs_rdata;
  logic              bs_rvalid;

  always #2 clk = ~clk;

  tcm_dual_port #(.MEM_BYTES(MEM_BYTES)) u_tcm_dual_port (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] model [NW];
  logic [31:0] e_fa = '0, e_bs = '0;
  logic        e_fav = 1'b0, e_bsv = 1'b0;

  function automatic logic [ADDR_W-1:0] baddr(input int w, input int low);
    return ADDR_W'(w * 4 + low);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock: update the model at the edge, compare away from it.
  task automatic cyc(input string req);
    int fw, bw;
    @(posedge clk);
    fw = int'(fa_addr) / 4;
    bw = int'(bs_addr) / 4;
    if (rst) begin
      e_fa = '0; e_bs = '0; e_fav = 1'b0; e_bsv = 1'b0;
    end else begin
      if (fa_rd)   e_fa = model[fw];
      if (bs_read) e_bs = model[bw];
      e_fav = fa_rd;
      e_bsv = bs_read;
      if (bs_write)
        for (int k = 0; k < 4; k++)
          if (bs_be[k]) model[bw][8*k +: 8] = bs_wdata[8*k +: 8];
    end
    @(negedge clk);
    chk(req, "fa_rvalid", {31'b0, fa_rvalid}, {31'b0, e_fav});
    chk(req, "bs_rvalid", {31'b0, bs_rvalid}, {31'b0, e_bsv});
    chk(req, "fa_rdata",  fa_rdata, e_fa);
    chk(req, "bs_rdata",  bs_rdata, e_bs);
  endtask

  task automatic quiet();
    fa_rd = 1'b0; bs_read = 1'b0; bs_write = 1'b0; bs_be = '0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) cyc("R1");
    @(negedge clk); rst = 1'b0;
    cyc("R1");

    // R4 + R2: fill every word; fetch reads the word written one cycle earlier.
    for (int i = 0; i < NW; i++) begin
      bs_write = 1'b1; bs_be = 4'hF; bs_addr = baddr(i, 0);
      bs_wdata = 32'hC3A50000 ^ (i * 32'h00010203);
      fa_rd = (i > 0); fa_addr = baddr(i > 0 ? i - 1 : 0, 0);
      cyc("R4");
    end
    quiet();

    // R3 + R2: independent reads on both ports, random words.
    for (int i = 0; i < 300; i++) begin
      fa_rd = 1'($urandom_range(0, 1)); fa_addr = baddr($urandom_range(0, NW - 1), 0);
      bs_read = 1'($urandom_range(0, 1)); bs_addr = baddr($urandom_range(0, NW - 1), 0);
      cyc("R3");
    end
    quiet();

    // R5: each byte-enable pattern to one word, then read back on both ports.
    for (int p = 0; p < 16; p++) begin
      bs_write = 1'b1; bs_be = 4'(p); bs_addr = baddr(5, 0);
      bs_wdata = 32'h11223344 + p * 32'h01010101;
      cyc("R5");
      quiet(); fa_rd = 1'b1; fa_addr = baddr(5, 0); bs_read = 1'b1; bs_addr = baddr(5, 0);
      cyc("R5");
      quiet();
    end

    // R6: fetch read colliding with bus write, and bus read+write same word.
    for (int i = 0; i < 40; i++) begin
      int w;
      w = $urandom_range(0, NW - 1);
      fa_rd = 1'b1; fa_addr = baddr(w, 0);
      bs_write = 1'b1; bs_addr = baddr(w, 0); bs_be = 4'($urandom_range(1, 15));
      bs_wdata = $urandom;
      bs_read = (i % 2 == 1);
      cyc("R6");
      quiet(); fa_rd = 1'b1; fa_addr = baddr(w, 0); bs_read = 1'b1; bs_addr = baddr(w, 0);
      cyc("R6");
      quiet();
    end

    // R7: outputs hold with no reads, even while writes happen.
    for (int i = 0; i < 20; i++) begin
      bs_write = (i % 3 == 0); bs_be = 4'hF; bs_addr = baddr(i, 0); bs_wdata = $urandom;
      cyc("R7");
    end
    quiet();

    // R8: low two address bits are ignored on both ports.
    for (int low = 0; low < 4; low++) begin
      fa_rd = 1'b1; fa_addr = baddr(77, low);
      bs_read = 1'b1; bs_addr = baddr(200, 3 - low);
      cyc("R8");
      quiet();
      bs_write = 1'b1; bs_be = 4'hF; bs_addr = baddr(77, low); bs_wdata = 32'hF00D0000 + low;
      cyc("R8");
      quiet(); fa_rd = 1'b1; fa_addr = baddr(77, 3 - low);
      cyc("R8");
      quiet();
    end

    cyc("R7");
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 200000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule